// File: doc/BRIEF.md
# Pulse Width and Interval Qualifier

The qualifier watches one synchronous trigger-source bit and measures spans of it in clock cycles. In width mode the span is one pulse: timing begins on the edge opposite to the selected one and the result is tested on the selected edge that ends the pulse. In interval mode the span is the time from one selected edge to the next. A selected edge restarts the timer, and the test is made on the edge that closes the interval.

The measured span is compared against two programmable limits. The at-most test passes when the span is no greater than its limit. The at-least test passes when the span is no smaller than its limit. Each test has its own enable. When both are enabled, they combine either with AND, which accepts only spans inside a window, or with OR, which accepts only spans outside it. A passing span produces a one-cycle trigger pulse.

The limits, the enables and the combine choice are copied into the block at the start of every measurement. The span counter holds at its largest value and does not wrap.

Top module: `pwq_qualifier`

## Requirements
- R1: Width mode (`meas_mode`=0): the span is the number of clock cycles from the rising `clk` edge that first samples the opposite edge of `src` to the one that first samples the selected edge. If `src` changes before rising edge k, `trig` is high from edge k+1 to edge k+2. The opposite edge never raises `trig`.
- R2: Interval mode (`meas_mode`=1): the span is the number of cycles between two consecutive selected edges. Every selected edge restarts the timer, and any trigger comes on the second edge of the pair, with the same latency as in R1.
- R3: With only `le_en`=1, a measurement triggers if and only if span <= `le_lim`.
- R4: With only `ge_en`=1, a measurement triggers if and only if span >= `ge_lim`.
- R5: With both enables set, `use_or`=0 triggers when both tests pass (inside the window). `use_or`=1 triggers when either test passes (outside the window).
- R6: With both enables clear, no measurement triggers.
- R7: The span counter saturates at 2^CNT_W-1 and does not wrap, so an over-long span still passes the at-least test and fails a larger at-most test.
- R8: After reset, and after any change of `meas_mode` or `sel_rise`, the first starting edge only arms the block. In interval mode the first selected edge therefore cannot trigger.
- R9: `le_lim`, `ge_lim`, `le_en`, `ge_en` and `use_or` are captured when a measurement starts. Changing them during a measurement has no effect on that measurement's result.
- R10: `trig` is low during and right after reset, and every trigger lasts exactly one clock cycle.
- R11: `sel_rise`=1 selects the rising edge of `src` and `sel_rise`=0 selects the falling edge. In width mode, `sel_rise`=1 measures low pulses and `sel_rise`=0 measures high pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 1 | Trigger-source bit, synchronous to clk |
| sel_rise | input | 1 | 1: rising edge selected, 0: falling edge selected |
| meas_mode | input | 1 | 0: pulse width, 1: interval between like edges |
| le_lim | input | CNT_W | Limit for the at-most test |
| ge_lim | input | CNT_W | Limit for the at-least test |
| le_en | input | 1 | Enable for the at-most test |
| ge_en | input | 1 | Enable for the at-least test |
| use_or | input | 1 | With both tests on: 1 = outside window (OR), 0 = inside window (AND) |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
A wrong arming state shows up at the next measurement as either a spurious trigger or a missing one. An example is a first interval edge that fires, or a mode switch that is not honoured. A counter that wraps, or one that restarts on the wrong edge, changes the span compared on the closing edge. That error appears on `trig` two cycles after the closing edge, and it is most visible at the limit boundaries and on spans longer than the counter can hold. A capture made at the wrong moment shows up when the limits change in the middle of a pulse, or between two interval edges: the result then follows the new settings instead of the old ones.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

  typedef enum logic {
    MEAS_WIDTH    = 1'b0,
    MEAS_INTERVAL = 1'b1
  } meas_mode_e;

  // Combine the two limit tests according to which are enabled.
  function automatic logic merge_tests(input logic le_ok,
                                       input logic ge_ok,
                                       input logic le_on,
                                       input logic ge_on,
                                       input logic any_side);
    case ({le_on, ge_on})
      2'b00:   return 1'b0;
      2'b10:   return le_ok;
      2'b01:   return ge_ok;
      default: return any_side ? (le_ok | ge_ok) : (le_ok & ge_ok);
    endcase
  endfunction

endpackage

// File: rtl/pwq_edge_det.sv
module pwq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic sel_rise,
  output logic sel_edge,
  output logic opp_edge
);
  logic smp_now;
  logic smp_prev;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_now  <= 1'b0;
      smp_prev <= 1'b0;
    end else begin
      smp_now  <= src;
      smp_prev <= smp_now;
    end
  end

  assign rise_w   = smp_now & ~smp_prev;
  assign fall_w   = ~smp_now & smp_prev;
  assign sel_edge = sel_rise ? rise_w : fall_w;
  assign opp_edge = sel_rise ? fall_w : rise_w;

endmodule

// File: rtl/pwq_span_ctr.sv
module pwq_span_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= CNT_ONE;
    else              cnt <= sat_inc(cnt);
  end

  // R2: a restart begins the count at one cycle
  a_r2_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == CNT_ONE);
  // R7: the count holds at its maximum
  a_r7_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !restart) |=> cnt == CNT_MAX);
  // R7: the count never wraps to zero
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> cnt != '0);

endmodule

// File: rtl/pwq_judge.sv
module pwq_judge #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CNT_W-1:0] le_lim,
  input  logic [CNT_W-1:0] ge_lim,
  input  logic             le_en,
  input  logic             ge_en,
  input  logic             use_or,
  input  logic [CNT_W-1:0] span,
  output logic             pass,
  output logic             any_en
);
  logic [CNT_W-1:0] le_q;
  logic [CNT_W-1:0] ge_q;
  logic             le_en_q;
  logic             ge_en_q;
  logic             or_q;

  function automatic logic at_most(input logic [CNT_W-1:0] v,
                                   input logic [CNT_W-1:0] lim);
    return v <= lim;
  endfunction

  function automatic logic at_least(input logic [CNT_W-1:0] v,
                                    input logic [CNT_W-1:0] lim);
    return v >= lim;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_q    <= '0;
      ge_q    <= '0;
      le_en_q <= 1'b0;
      ge_en_q <= 1'b0;
      or_q    <= 1'b0;
    end else if (capture) begin
      le_q    <= le_lim;
      ge_q    <= ge_lim;
      le_en_q <= le_en;
      ge_en_q <= ge_en;
      or_q    <= use_or;
    end
  end

  assign pass = pwq_pkg::merge_tests(at_most(span, le_q), at_least(span, ge_q),
                                     le_en_q, ge_en_q, or_q);
  assign any_en = le_en_q | ge_en_q;

  // R9: captured settings hold between measurement starts
  a_r9_hold_limits: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(le_q) && $stable(ge_q) && $stable(or_q)));

endmodule

// File: rtl/pwq_qualifier.sv
module pwq_qualifier #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic             sel_rise,
  input  logic             meas_mode,
  input  logic [CNT_W-1:0] le_lim,
  input  logic [CNT_W-1:0] ge_lim,
  input  logic             le_en,
  input  logic             ge_en,
  input  logic             use_or,
  output logic             trig
);
  import pwq_pkg::*;

  meas_mode_e       mode_e;
  logic             mode_q;
  logic             pol_q;
  logic             cfg_chg;
  logic             sel_edge;
  logic             opp_edge;
  logic             start_ev;
  logic             end_ev;
  logic             armed;
  logic             pass;
  logic             any_en;
  logic             fire;
  logic [CNT_W-1:0] span;

  assign mode_e = meas_mode_e'(meas_mode);

  pwq_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .sel_rise (sel_rise),
    .sel_edge (sel_edge),
    .opp_edge (opp_edge)
  );

  assign start_ev = (mode_e == MEAS_INTERVAL) ? sel_edge : opp_edge;
  assign end_ev   = sel_edge;

  pwq_span_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_ev),
    .cnt     (span)
  );

  pwq_judge #(.CNT_W(CNT_W)) u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (start_ev),
    .le_lim  (le_lim),
    .ge_lim  (ge_lim),
    .le_en   (le_en),
    .ge_en   (ge_en),
    .use_or  (use_or),
    .span    (span),
    .pass    (pass),
    .any_en  (any_en)
  );

  assign cfg_chg = (meas_mode != mode_q) | (sel_rise != pol_q);
  assign fire    = end_ev & armed & ~cfg_chg & pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pol_q  <= 1'b0;
      armed  <= 1'b0;
      trig   <= 1'b0;
    end else begin
      mode_q <= meas_mode;
      pol_q  <= sel_rise;
      trig   <= fire;
      if (cfg_chg)                                armed <= 1'b0;
      else if (start_ev)                          armed <= 1'b1;
      else if (end_ev && mode_e == MEAS_WIDTH)    armed <= 1'b0;
    end
  end

  // R10: a trigger lasts one cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R1: a trigger follows a selected edge
  a_r1_on_end_edge: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(end_ev));
  // R8: no trigger without a started measurement
  a_r8_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed));
  // R8: a change of mode or polarity suppresses the trigger
  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_chg) |-> !trig);
  // R6: a trigger requires at least one enabled test
  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(any_en));

endmodule

// File: tb/pwq_qualifier_tb.sv
module pwq_qualifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src = 1'b0;
  logic        sel_rise = 1'b0;
  logic        meas_mode = 1'b0;
  logic [31:0] le_lim = '0;
  logic [31:0] ge_lim = '0;
  logic [5:0]  le_s = '0;
  logic [5:0]  ge_s = '0;
  logic        le_en = 1'b0;
  logic        ge_en = 1'b0;
  logic        use_or = 1'b0;
  logic        trig;
  logic        trig_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state for interval mode
  bit          armed_m = 0;
  int          last_p = 0;
  logic [31:0] c_le, c_ge;
  bit          c_len, c_gen, c_or;

  always #10 clk = ~clk;

  pwq_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .src(src), .sel_rise(sel_rise),
    .meas_mode(meas_mode), .le_lim(le_lim), .ge_lim(ge_lim),
    .le_en(le_en), .ge_en(ge_en), .use_or(use_or), .trig(trig));

  pwq_qualifier #(.CNT_W(6)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .src(src), .sel_rise(sel_rise),
    .meas_mode(meas_mode), .le_lim(le_s), .ge_lim(ge_s),
    .le_en(le_en), .ge_en(ge_en), .use_or(use_or), .trig(trig_s));

  // expected verdict restated from R3..R6
  function automatic bit exp_pass(input longint span, input longint le, input longint ge,
                                  input bit len, input bit gen, input bit oor);
    bit below, above;
    below = (span <= le);
    above = (span >= ge);
    if (len && gen) begin
      if (oor) return below || above;
      return below && above;
    end
    if (len) return below;
    if (gen) return above;
    return 0;
  endfunction

  function automatic string tag_of(input bit len, input bit gen);
    if (len && gen) return "R5";
    if (len)        return "R3";
    if (gen)        return "R4";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic set_cfg(input int le, input int ge, input bit len, input bit gen, input bit oor);
    le_lim = le; ge_lim = ge; le_s = 6'(le); ge_s = 6'(ge);
    le_en = len; ge_en = gen; use_or = oor;
  endtask

  // width-mode pulse of w cycles, then idle for gap cycles (gap >= 3)
  task automatic pw(input int w, input int gap, input bit chg);
    logic [31:0] s_le, s_ge;
    logic [5:0]  s_les, s_ges;
    bit s_len, s_gen, s_or, e_main, e_sat;
    string tg;
    int span_s;
    s_le = le_lim; s_ge = ge_lim; s_les = le_s; s_ges = ge_s;
    s_len = le_en; s_gen = ge_en; s_or = use_or;
    src = ~sel_rise;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      if (i == 2 && w >= 3) chk("R1 opposite edge", trig, 1'b0);
      if (i == 3 && chg) begin
        le_lim = 32'd1; ge_lim = 32'd1000; le_s = 6'd1; ge_s = 6'd60;
        le_en = ~s_len; ge_en = ~s_gen; use_or = ~s_or;
      end
    end
    src = sel_rise;
    e_main = exp_pass(w, s_le, s_ge, s_len, s_gen, s_or);
    span_s = (w > 63) ? 63 : w;
    e_sat = exp_pass(span_s, s_les, s_ges, s_len, s_gen, s_or);
    tg = chg ? "R9" : tag_of(s_len, s_gen);
    @(negedge clk);
    chk("R1 early", trig, 1'b0);
    @(negedge clk);
    chk($sformatf("R1 %s width %0d", tg, w), trig, e_main);
    chk($sformatf("R7 %s sat width %0d", tg, w), trig_s, e_sat);
    @(negedge clk);
    chk("R10 single cycle", trig, 1'b0);
    repeat (gap - 3) @(negedge clk);
  endtask

  // interval-mode selected edge; the next call comes p cycles later (p >= 2)
  task automatic iv(input int p);
    bit e;
    string tg;
    e = armed_m && exp_pass(last_p, c_le, c_ge, c_len, c_gen, c_or);
    tg = armed_m ? $sformatf("R2 %s", tag_of(c_len, c_gen)) : "R2 R8 first edge";
    src = sel_rise;
    @(negedge clk);
    src = ~sel_rise;
    chk("R10 idle", trig, 1'b0);
    @(negedge clk);
    chk($sformatf("%s span %0d", tg, last_p), trig, e);
    c_le = le_lim; c_ge = ge_lim; c_len = le_en; c_gen = ge_en; c_or = use_or;
    armed_m = 1; last_p = p;
    repeat (p - 2) @(negedge clk);
  endtask

  task automatic rand_cfg();
    set_cfg($urandom % 40, $urandom % 40, 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R10 reset", trig, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 after reset", trig, 1'b0);

    // width mode, high pulses (R11 with sel_rise=0)
    set_cfg(10, 0, 1, 0, 0); pw(10, 4, 0); pw(11, 4, 0);
    set_cfg(0, 10, 0, 1, 0); pw(10, 4, 0); pw(9, 4, 0);
    set_cfg(8, 5, 1, 1, 0);  pw(5, 4, 0); pw(8, 4, 0); pw(9, 4, 0); pw(4, 3, 0);
    set_cfg(5, 8, 1, 1, 1);  pw(5, 4, 0); pw(6, 4, 0); pw(8, 4, 0);
    set_cfg(5, 0, 0, 0, 1);  pw(3, 4, 0); pw(7, 4, 0);
    set_cfg(10, 0, 1, 0, 0); pw(6, 4, 1);
    set_cfg(0, 10, 0, 1, 0); pw(6, 4, 1);
    // R7 saturation on the 6-bit instance
    set_cfg(0, 50, 0, 1, 0); ge_s = 6'd40; pw(100, 4, 0);
    set_cfg(70, 0, 1, 0, 0); le_s = 6'd50; pw(100, 4, 0);

    // R11 low pulses with sel_rise=1
    sel_rise = 1'b1; src = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 polarity switch", trig, 1'b0);
    set_cfg(10, 0, 1, 0, 0); pw(10, 4, 0); pw(12, 4, 0);
    set_cfg(0, 4, 0, 1, 0);  pw(4, 4, 0); pw(3, 4, 0);

    // random width pulses
    for (int n = 0; n < 25; n++) begin
      bit c;
      rand_cfg();
      c = ($urandom % 4) == 0;
      pw(4 + ($urandom % 37), 3 + ($urandom % 5), c);
    end

    // interval mode, rising edges
    sel_rise = 1'b1; src = 1'b0; meas_mode = 1'b1; armed_m = 0;
    repeat (5) @(negedge clk);
    set_cfg(0, 0, 0, 1, 0);
    iv(6); iv(6);
    set_cfg(6, 0, 1, 0, 0);
    iv(7); iv(5); iv(4); iv(8);
    // R8 after a mode switch
    meas_mode = 1'b0; repeat (4) @(negedge clk);
    meas_mode = 1'b1; repeat (4) @(negedge clk);
    armed_m = 0;
    set_cfg(0, 0, 0, 1, 0);
    iv(5); iv(5); iv(5);
    // falling-edge intervals
    sel_rise = 1'b0; src = 1'b1; armed_m = 0;
    repeat (5) @(negedge clk);
    set_cfg(9, 3, 1, 1, 0);
    iv(3); iv(9); iv(2); iv(10); iv(4);
    // random intervals
    for (int n = 0; n < 25; n++) begin
      rand_cfg();
      iv(2 + ($urandom % 39));
    end
    iv(5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule